// File: doc/BRIEF.md
# Paired-Channel Double-Data-Rate Parallel Bridge

This block sits between a set of per-channel parallel word paths and a narrow source-synchronous bus that moves two channels over one group of pins by using both clock edges. Channels are grouped in fixed pairs (A/B, C/D, E/F, G/H). Within a pair, the lettered channel that comes first (A, C, E, G) is the "lead" channel and travels on the falling edge. The second channel (B, D, F, H) is the "trail" channel and travels on the rising edge. The bus clock is the block clock `clk`, which is forwarded unchanged as the source-synchronous clock.

On transmit, both words of every pair are registered on a rising edge. The bus then carries the lead word for the high phase that follows, so the far end captures it on the falling edge. It carries the trail word for the low phase, so the far end captures it on the next rising edge. On receive, the lead word is captured on the falling edge and registered again on the next rising edge, where the trail word is also captured. Both words of each pair then appear together in the rising-edge domain with a single valid flag.

Words are 10 bits wide when the data is already line-coded and 8 bits wide when it is not. The width is chosen by a mode input that is sampled only while reset is held.

Top module: `ddr_pair_bridge`

## Requirements
- R1: Pair p occupies bus bits [p*10+9 : p*10], with pair 0 being A/B. During the high phase of `clk`, `ddr_tx_data` carries each pair's lead-channel word, which is the value a receiver samples on the falling edge.
- R2: The words on `tx_lead_word`/`tx_trail_word` sampled at a rising edge are driven in the clock period that starts at that edge: the lead word during the high phase, then the trail word during the low phase.
- R3: The bus value present at a falling edge appears on `rx_lead_word`, and the bus value present at the following rising edge appears on `rx_trail_word`. Both are updated together at that rising edge.
- R4: With the latched mode set to wide (`wide_mode`=1), all 10 bits of every word pass unchanged in both directions.
- R5: With the latched mode set to narrow (`wide_mode`=0), bits 9:8 of every pair slice on `ddr_tx_data` are driven 0, and bits 9:8 of every received word are 0 whatever the bus carries there. Bits 7:0 pass unchanged.
- R6: `rx_valid` is 0 during reset. It rises at the second rising edge at which `rst_n` is sampled high and then stays 1 until the next reset.
- R7: `wide_mode` is sampled only at rising edges where `rst_n` is 0. Changing it while out of reset has no effect on either direction.
- R8: During reset, `ddr_tx_data` is 0 in both clock phases and both received word outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the forwarded bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 10-bit coded words, 0 = 8-bit plain words; taken during reset |
| tx_lead_word | input | 40 | Lead-channel (A,C,E,G) transmit words, 10 bits per pair |
| tx_trail_word | input | 40 | Trail-channel (B,D,F,H) transmit words, 10 bits per pair |
| ddr_tx_data | output | 40 | Transmit double-data-rate bus |
| ddr_rx_data | input | 40 | Receive double-data-rate bus |
| rx_lead_word | output | 40 | Lead-channel words recovered from falling-edge samples |
| rx_trail_word | output | 40 | Trail-channel words recovered from rising-edge samples |
| rx_valid | output | 1 | Received word pairs are valid |

## Verification
The hardest case to reach is a mode change while the block is out of reset. It has to show no effect on either direction, and it is only visible through bits 9:8. The stimulus runs a narrow-mode stretch in which the receive bus and the transmit words carry ones in those bits. Partway through, it raises `wide_mode` without reset and keeps checking that those bits stay clear. The bench also drives the receive bus separately in each half period, so the falling-edge and rising-edge samples always hold different words. A swapped edge assignment therefore cannot pass.

// File: rtl/ddrmux_pkg.sv
// Shared constants and word trimming for the paired-channel DDR bridge.
package ddrmux_pkg;
    localparam int WORD_W   = 10;
    localparam int NARROW_W = 8;

    // Clears the bits above the narrow width when the wide mode is off.
    function automatic logic [WORD_W-1:0] trim_word(input logic [WORD_W-1:0] w,
                                                    input logic wide);
        return wide ? w : {{(WORD_W-NARROW_W){1'b0}}, w[NARROW_W-1:0]};
    endfunction
endpackage

// File: rtl/pair_tx_launch.sv
// Transmit side: registers both words of each pair on the rising edge and
// drives the lead word in the high phase and the trail word in the low phase.
// Assumes wide_q is stable while out of reset.
module pair_tx_launch
    import ddrmux_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wide_q,
    input  logic [NUM_PAIRS*WORD_W-1:0]   lead_in,
    input  logic [NUM_PAIRS*WORD_W-1:0]   trail_in,
    output logic [NUM_PAIRS*WORD_W-1:0]   bus_out
);
    localparam int BUS_W = NUM_PAIRS * WORD_W;

    logic [BUS_W-1:0]     lead_m, trail_m;
    logic [BUS_W-1:0]     lead_q, trail_q, trail_hold;
    logic [NUM_PAIRS-1:0] lead_hi;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign lead_m[p*WORD_W +: WORD_W]  = trim_word(lead_in[p*WORD_W +: WORD_W], wide_q);
        assign trail_m[p*WORD_W +: WORD_W] = trim_word(trail_in[p*WORD_W +: WORD_W], wide_q);
        assign lead_hi[p] = |lead_q[p*WORD_W+NARROW_W +: WORD_W-NARROW_W];
    end

    // Capture both words of every pair on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q  <= '0;
            trail_q <= '0;
        end else begin
            lead_q  <= lead_m;
            trail_q <= trail_m;
        end
    end

    // Hand the trail word over to the falling-edge launch register.
    always_ff @(negedge clk) begin
        if (!rst_n) trail_hold <= '0;
        else        trail_hold <= trail_q;
    end

    // High phase carries the lead word, low phase the trail word.
    assign bus_out = clk ? lead_q : trail_hold;

    // R2: the low-phase register always holds the word captured at the last rise
    p_trail_handoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> trail_hold == trail_q);

    // R5: narrow mode never launches upper bits
    p_tx_narrow_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !wide_q |-> lead_hi == '0);
endmodule

// File: rtl/pair_rx_split.sv
// Receive side: captures the lead word on the falling edge and moves it into
// the rising-edge domain together with the trail word captured on the rise.
// Assumes wide_q is stable while out of reset.
module pair_rx_split
    import ddrmux_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wide_q,
    input  logic [NUM_PAIRS*WORD_W-1:0]   bus_in,
    output logic [NUM_PAIRS*WORD_W-1:0]   lead_out,
    output logic [NUM_PAIRS*WORD_W-1:0]   trail_out,
    output logic                          valid_out
);
    localparam int BUS_W = NUM_PAIRS * WORD_W;

    logic [BUS_W-1:0]     lead_cap, lead_m, trail_m;
    logic                 armed;
    logic [NUM_PAIRS-1:0] out_hi;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign lead_m[p*WORD_W +: WORD_W]  = trim_word(lead_cap[p*WORD_W +: WORD_W], wide_q);
        assign trail_m[p*WORD_W +: WORD_W] = trim_word(bus_in[p*WORD_W +: WORD_W], wide_q);
        assign out_hi[p] = |{lead_out[p*WORD_W+NARROW_W +: WORD_W-NARROW_W],
                             trail_out[p*WORD_W+NARROW_W +: WORD_W-NARROW_W]};
    end

    // Sample the lead words on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) lead_cap <= '0;
        else        lead_cap <= bus_in;
    end

    // Present both words of each pair on the rising edge and track validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_out  <= '0;
            trail_out <= '0;
            armed     <= 1'b0;
            valid_out <= 1'b0;
        end else begin
            lead_out  <= lead_m;
            trail_out <= trail_m;
            armed     <= 1'b1;
            valid_out <= armed;
        end
    end

    // R6: once valid, stays valid until reset
    p_valid_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |=> valid_out);

    // R5: narrow mode presents no upper bits
    p_rx_narrow_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !wide_q |-> out_hi == '0);
endmodule

// File: rtl/ddr_pair_bridge.sv
// Top of the paired-channel DDR bridge: latches the width mode during reset
// and connects the transmit launch and receive split paths.
// Assumes clk is the forwarded source-synchronous clock in both directions.
module ddr_pair_bridge
    import ddrmux_pkg::*;
#(
    parameter int NUM_PAIRS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wide_mode,
    input  logic [NUM_PAIRS*WORD_W-1:0]   tx_lead_word,
    input  logic [NUM_PAIRS*WORD_W-1:0]   tx_trail_word,
    output logic [NUM_PAIRS*WORD_W-1:0]   ddr_tx_data,
    input  logic [NUM_PAIRS*WORD_W-1:0]   ddr_rx_data,
    output logic [NUM_PAIRS*WORD_W-1:0]   rx_lead_word,
    output logic [NUM_PAIRS*WORD_W-1:0]   rx_trail_word,
    output logic                          rx_valid
);
    logic wide_q;

    // Take the width mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) wide_q <= wide_mode;
    end

    pair_tx_launch #(.NUM_PAIRS(NUM_PAIRS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_q   (wide_q),
        .lead_in  (tx_lead_word),
        .trail_in (tx_trail_word),
        .bus_out  (ddr_tx_data)
    );

    pair_rx_split #(.NUM_PAIRS(NUM_PAIRS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_q    (wide_q),
        .bus_in    (ddr_rx_data),
        .lead_out  (rx_lead_word),
        .trail_out (rx_trail_word),
        .valid_out (rx_valid)
    );

    // R7: mode cannot move while out of reset
    p_mode_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(wide_q));
endmodule

// File: tb/ddr_pair_bridge_test.sv
module ddr_pair_bridge_test;
    localparam int NP = 4;
    localparam int BW = NP * 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b1;
    logic [BW-1:0] tx_lead_word = '0, tx_trail_word = '0, ddr_rx_data = '0;
    logic [BW-1:0] ddr_tx_data, rx_lead_word, rx_trail_word;
    logic          rx_valid;

    always #4 clk = ~clk;

    ddr_pair_bridge #(.NUM_PAIRS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .tx_lead_word(tx_lead_word), .tx_trail_word(tx_trail_word),
        .ddr_tx_data(ddr_tx_data), .ddr_rx_data(ddr_rx_data),
        .rx_lead_word(rx_lead_word), .rx_trail_word(rx_trail_word),
        .rx_valid(rx_valid)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Model state: what went in one period earlier and the mode in force.
    logic [BW-1:0] prev_txl, prev_txt, prev_rxl, prev_rxt;
    bit mode_eff;
    int since;

    function automatic logic [BW-1:0] msk(logic [BW-1:0] v, bit wide);
        for (int p = 0; p < NP; p++) if (!wide) v[p*10+8 +: 2] = 2'b00;
        return v;
    endfunction

    function automatic logic [BW-1:0] rnd();
        return BW'({$urandom(), $urandom()});
    endfunction

    task automatic chk(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // R8 / R6: hold reset, check idle outputs, release at mid low phase.
    task automatic do_reset(bit wide);
        rst_n = 0; wide_mode = wide;
        tx_lead_word = '0; tx_trail_word = '0; ddr_rx_data = '0;
        repeat (3) @(posedge clk);
        #2 chk("R8 tx high phase", ddr_tx_data, '0);
        #4 chk("R8 tx low phase", ddr_tx_data, '0);
        chk("R8 rx lead", rx_lead_word, '0);
        chk("R8 rx trail", rx_trail_word, '0);
        chk("R6 valid in reset", BW'(rx_valid), '0);
        rst_n = 1;
        mode_eff = wide;
        prev_txl = '0; prev_txt = '0; prev_rxl = '0; prev_rxt = '0;
        since = 0;
    endtask

    // One clock period of stimulus and comparison against the model.
    task automatic step(logic [BW-1:0] txl, logic [BW-1:0] txt,
                        logic [BW-1:0] rxl, logic [BW-1:0] rxt);
        @(posedge clk); #1;
        since++;
        chk("R6 valid", BW'(rx_valid), BW'(since >= 2));
        chk(mode_eff ? "R3/R4 rx lead" : "R3/R5 rx lead", rx_lead_word, msk(prev_rxl, mode_eff));
        chk(mode_eff ? "R3/R4 rx trail" : "R3/R5 rx trail", rx_trail_word, msk(prev_rxt, mode_eff));
        #1;
        chk(mode_eff ? "R1/R4 tx lead phase" : "R1/R5 tx lead phase", ddr_tx_data, msk(prev_txl, mode_eff));
        ddr_rx_data = rxl;
        #4;
        chk(mode_eff ? "R2/R4 tx trail phase" : "R2/R5 tx trail phase", ddr_tx_data, msk(prev_txt, mode_eff));
        ddr_rx_data = rxt;
        tx_lead_word = txl; tx_trail_word = txt;
        prev_txl = txl; prev_txt = txt; prev_rxl = rxl; prev_rxt = rxt;
    endtask

    initial begin
        // Wide mode: directed edge patterns then random traffic (R1..R4).
        do_reset(1'b1);
        step({NP{10'h3FF}}, '0, {NP{10'h3FF}}, '0);
        step('0, {NP{10'h3FF}}, '0, {NP{10'h3FF}});
        step({10'h301, 10'h202, 10'h103, 10'h004}, {10'h0F0, 10'h1E1, 10'h2D2, 10'h3C3},
             {10'h155, 10'h2AA, 10'h311, 10'h0EE}, {10'h2AA, 10'h155, 10'h0EE, 10'h311});
        for (int i = 0; i < 20; i++) step(rnd(), rnd(), rnd(), rnd());
        step('0, '0, '0, '0);

        // Narrow mode: upper bits set everywhere must be cleared (R5).
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) step({NP{10'h3FF}}, rnd(), rnd(), {NP{10'h300}} | rnd());
        // R7: raise the mode without reset; narrow behaviour must persist.
        wide_mode = 1'b1;
        for (int i = 0; i < 10; i++) step(rnd() | {NP{10'h300}}, rnd(), {NP{10'h3FF}}, rnd());
        step('0, '0, '0, '0);

        // Back to wide through reset: upper bits pass again (R4, R7).
        do_reset(1'b1);
        for (int i = 0; i < 6; i++) step({NP{10'h300}} | rnd(), rnd(), {NP{10'h300}}, rnd());
        step('0, '0, '0, '0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule